// File: doc/BRIEF.md
# Lock-Ready Transition-Density Detector

This block decides when received data may be trusted after the clock-recovery loop changes its acquisition mode. It watches the received data bit and counts its rising edges into a leaky, saturating accumulator. Every rising data edge adds a fixed charge. A constant leak removes one unit at a fixed interval. Any change of the acquisition-mode select, in either direction, empties the accumulator and withdraws readiness.

The ready output is active-low: low means the recovered data is valid. It goes low once the accumulator reaches an upper threshold. It stays low until the accumulator falls below a lower threshold, and this hysteresis keeps the flag from chattering. Dense data therefore gives readiness after a short delay. Sparse data delays readiness or never grants it. When data activity dies away after readiness, the flag lapses again.

An output-enable input forces the flag to its not-ready level, for board test. The charge, leak interval, thresholds and saturation limit are parameters counted in clock ticks. They are sized for the system clock so that dense data gives readiness within the required window. All pins are plain level signals sampled on one clock. There is no stream handshake, so no back-pressure applies.

Top module: `lock_ready_detect`

## Requirements
- R1: After reset the accumulator is zero and `ready_n` is 1.
- R2: A rising edge of `rx_bit` (0 in the previous cycle, 1 in this cycle) adds `INC` to the accumulator. A falling edge or a steady level adds nothing.
- R3: The accumulator loses one unit every `LEAK_DIV` cycles. It never goes below zero, so a long quiet period leaves it at zero and not wrapped to a large value.
- R4: One cycle after the accumulator holds a value of at least `THRESH_HI`, the internal ready flag is set and `ready_n` drives 0 while `out_en` is 1.
- R5: Once set, the ready flag stays set while the accumulator stays at or above `THRESH_LO`. It clears one cycle after the accumulator falls below `THRESH_LO`.
- R6: Any change of `acq_mode`, whether 0 to 1 or 1 to 0, clears the accumulator and the ready flag at the next clock edge. `ready_n` is 1 in the following cycle.
- R7: The accumulator saturates at `ACC_MAX` and never wraps, however long dense data lasts.
- R8: While `out_en` is 0, `ready_n` is 1 in the same cycle, whatever the internal state. Restoring `out_en` to 1 shows the internal flag again.
- R9: When rising data edges are too sparse for `INC` to outrun the leak (one rise per 32 cycles with the bench values), `ready_n` never goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Recovered received data bit |
| acq_mode | input | 1 | Acquisition-mode select; any change restarts the detection |
| out_en | input | 1 | Output enable; 0 forces `ready_n` high |
| ready_n | output | 1 | Active-low data-valid flag |

## Verification
The bench builds the block with `INC`=4, `LEAK_DIV`=4, `ACC_MAX`=63, `THRESH_HI`=32 and `THRESH_LO`=24. With these values, data toggling every cycle fills the accumulator to its ceiling within about forty cycles. The slow leak back down from the ceiling takes about 160 cycles, which leaves a wide band where the accumulator sits between the two thresholds. That band is where the bench checks the hysteresis. The same small values put the wrap-around and underflow points within a short run. A rise every 32 cycles loses to the leak, so the sparse case settles quickly as well.

// File: rtl/lock_ready_pkg.sv
package lock_ready_pkg;
  // Saturating add of a charge followed by an optional one-unit leak.
  function automatic int unsigned charge_step(
    input int unsigned cur,
    input int unsigned add,
    input logic        leak,
    input int unsigned cap
  );
    int unsigned v;
    v = cur + add;
    if (leak && v != 0) v = v - 1;
    if (v > cap) v = cap;
    return v;
  endfunction
endpackage

// File: rtl/rdy_edge_detect.sv
module rdy_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic change
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign rise   = sig & ~prev_q;
  assign change = sig ^ prev_q;
endmodule

// File: rtl/rdy_leak_timer.sv
module rdy_leak_timer #(
  parameter int LEAK_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (LEAK_DIV > 1) ? $clog2(LEAK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEAK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/rdy_accum.sv
module rdy_accum
  import lock_ready_pkg::*;
#(
  parameter int ACC_W   = 8,
  parameter int INC     = 8,
  parameter int ACC_MAX = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rise,
  input  logic             leak,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] acc_q;
  int unsigned      nxt;

  always_comb begin
    nxt = charge_step(int'(acc_q), rise ? INC : 0, leak, ACC_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else            acc_q <= nxt[ACC_W-1:0];
  end

  assign acc = acc_q;
endmodule

// File: rtl/rdy_flag.sv
module rdy_flag #(
  parameter int ACC_W     = 8,
  parameter int THRESH_HI = 192,
  parameter int THRESH_LO = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [ACC_W-1:0] acc,
  output logic             ready
);
  localparam logic [ACC_W-1:0] HI = ACC_W'(THRESH_HI);
  localparam logic [ACC_W-1:0] LO = ACC_W'(THRESH_LO);

  logic ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ready_q <= 1'b0;
    else if (clear)     ready_q <= 1'b0;
    else if (acc >= HI) ready_q <= 1'b1;
    else if (acc < LO)  ready_q <= 1'b0;
  end

  assign ready = ready_q;
endmodule

// File: rtl/lock_ready_detect.sv
module lock_ready_detect #(
  parameter int INC       = 8,
  parameter int LEAK_DIV  = 16,
  parameter int ACC_MAX   = 255,
  parameter int THRESH_HI = 192,
  parameter int THRESH_LO = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic acq_mode,
  input  logic out_en,
  output logic ready_n
);
  localparam int ACC_W = $clog2(ACC_MAX + 1);

  logic             data_rise;
  logic             data_chg;
  logic             mode_rise;
  logic             mode_chg;
  logic             leak_tick;
  logic [ACC_W-1:0] acc_q;
  logic             ready_q;

  rdy_edge_detect i_data_edge (
    .clk(clk), .rst_n(rst_n), .sig(rx_bit), .rise(data_rise), .change(data_chg)
  );

  rdy_edge_detect i_mode_edge (
    .clk(clk), .rst_n(rst_n), .sig(acq_mode), .rise(mode_rise), .change(mode_chg)
  );

  rdy_leak_timer #(.LEAK_DIV(LEAK_DIV)) i_leak (
    .clk(clk), .rst_n(rst_n), .tick(leak_tick)
  );

  rdy_accum #(.ACC_W(ACC_W), .INC(INC), .ACC_MAX(ACC_MAX)) i_accum (
    .clk(clk), .rst_n(rst_n), .clear(mode_chg), .rise(data_rise),
    .leak(leak_tick), .acc(acc_q)
  );

  rdy_flag #(.ACC_W(ACC_W), .THRESH_HI(THRESH_HI), .THRESH_LO(THRESH_LO)) i_flag (
    .clk(clk), .rst_n(rst_n), .clear(mode_chg), .acc(acc_q), .ready(ready_q)
  );

  assign ready_n = ~(ready_q & out_en);
endmodule

// File: rtl/lock_ready_detect_chk.sv
module lock_ready_detect_chk #(
  parameter int ACC_W     = 8,
  parameter int INC       = 8,
  parameter int ACC_MAX   = 255,
  parameter int THRESH_HI = 192,
  parameter int THRESH_LO = 160
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_en,
  input logic             ready_n,
  input logic             rise,
  input logic             mode_chg,
  input logic [ACC_W-1:0] acc,
  input logic             ready_q
);
  a_r8_enable_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> ready_n);

  a_r6_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (acc == '0 && !ready_q));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc) <= ACC_MAX);

  a_r4_ready_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc) >= THRESH_HI && !mode_chg) |=> ready_q);

  a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && int'(acc) >= THRESH_LO && !mode_chg) |=> ready_q);

  a_r3_leak_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !mode_chg) |=> acc <= $past(acc));

  a_r2_rise_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !mode_chg && int'(acc) + INC <= ACC_MAX) |=> acc > $past(acc));
endmodule

bind lock_ready_detect lock_ready_detect_chk #(
  .ACC_W(ACC_W), .INC(INC), .ACC_MAX(ACC_MAX),
  .THRESH_HI(THRESH_HI), .THRESH_LO(THRESH_LO)
) i_chk (
  .clk(clk), .rst_n(rst_n), .out_en(out_en), .ready_n(ready_n),
  .rise(data_rise), .mode_chg(mode_chg), .acc(acc_q), .ready_q(ready_q)
);

// File: tb/test_lock_ready_detect.sv
module test_lock_ready_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0;
  logic acq_mode = 1'b0;
  logic out_en = 1'b1;
  logic ready_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lock_ready_detect #(
    .INC(4), .LEAK_DIV(4), .ACC_MAX(63), .THRESH_HI(32), .THRESH_LO(24)
  ) i_lock_ready_detect (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .acq_mode(acq_mode),
    .out_en(out_en), .ready_n(ready_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dense(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_bit = ~rx_bit;
    end
  endtask

  // Flip the mode select and confirm the flag is withdrawn (R6)
  task automatic flip_mode(input string tag);
    @(negedge clk);
    acq_mode = ~acq_mode;
    @(negedge clk);
    check(tag, int'(ready_n), 1);
  endtask

  // Toggle data until ready_n falls; return cycle count (R4)
  task automatic time_to_ready(output int cyc);
    cyc = 0;
    while (ready_n && cyc < 100) begin
      @(negedge clk);
      rx_bit = ~rx_bit;
      cyc++;
    end
  endtask

  task automatic t_reset;
    idle(3);
    check("R1 reset ready_n", int'(ready_n), 1);
  endtask

  task automatic t_dense_ready;
    int cyc;
    time_to_ready(cyc);
    // R2/R4: at most INC per two cycles, so 32 needs more than 8 cycles; must arrive by 40
    check("R4 ready not before 9 cycles", int'(cyc >= 9), 1);
    check("R4 ready within 40 cycles", int'(cyc <= 40), 1);
  endtask

  task automatic t_enable;
    @(negedge clk);
    out_en = 1'b0;
    #1;
    check("R8 out_en low forces high", int'(ready_n), 1);
    idle(3);
    check("R8 still high while disabled", int'(ready_n), 1);
    out_en = 1'b1;
    #1;
    check("R8 restored flag shows", int'(ready_n), 0);
  endtask

  task automatic t_saturate_and_hysteresis;
    int drops = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rx_bit = ~rx_bit;
      if (ready_n) drops++;
    end
    check("R7 no wrap during long dense run", drops, 0);
    idle(140);
    check("R5 held between thresholds", int'(ready_n), 0);
    idle(40);
    check("R5 lapses below low threshold", int'(ready_n), 1);
  endtask

  task automatic t_sparse;
    int lows = 0;
    flip_mode("R6 clear before sparse run");
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      rx_bit = 1'b1;
      @(negedge clk);
      rx_bit = 1'b0;
      for (int j = 0; j < 30; j++) begin
        @(negedge clk);
        if (!ready_n) lows++;
      end
    end
    check("R9 sparse data never ready", lows, 0);
  endtask

  task automatic t_floor;
    int cyc;
    int lows = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!ready_n) lows++;
    end
    check("R3 long idle stays not ready", lows, 0);
    time_to_ready(cyc);
    check("R3 floor at zero, full delay again", int'(cyc >= 9), 1);
  endtask

  task automatic t_mode_edges;
    int cyc;
    check("R6 ready before mode change", int'(ready_n), 0);
    flip_mode("R6 mode change clears");
    time_to_ready(cyc);
    check("R6 restart after mode change", int'(cyc >= 9 && cyc <= 40), 1);
    flip_mode("R6 opposite mode change clears");
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    t_reset();
    t_dense_ready();
    t_enable();
    t_saturate_and_hysteresis();
    t_sparse();
    t_floor();
    t_mode_edges();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule